// File: doc/BRIEF.md
# Instruction Cycle-Cost Timing Unit

This block works out how many clock cycles one instruction of a small 8-bit processor costs, and then spends exactly that many cycles as a stall. A decoder upstream supplies the instruction description: a timing class, an addressing mode, a write flag, a page-cross flag from the index adder and a branch-taken flag. The cost is built from a base figure for each class and mode, plus penalty cycles for indexed writes, page crossings and taken branches. The block computes no addresses and moves no data.

When `start` is accepted, the cost is latched and shown on `cost`, and `busy` goes high for that many clocks. `done` then pulses for one cycle. A new `start` may be accepted in the last busy cycle, so two instructions can run with no idle gap. All pins are plain level controls with no back-pressure. The block is never stalled by what follows it, and the caller watches `busy` to know when `start` will be taken.

Top module: `cyc_timer`

## Requirements
- R1: Class codes are read=0, read-modify-write=1, simple implied=2, push=3, pull=4, return=5, break=6, branch=7, jump=8, call=9. Mode codes are none=0, immediate=1, zero page=2, zero page indexed=3, absolute=4, absolute indexed=5, pre-indexed indirect=6, post-indexed indirect=7, indirect=8, relative=9. A read-class instruction costs 2 for immediate, 3 for zero page, 4 for zero page indexed, absolute and absolute indexed, 6 for pre-indexed indirect and 5 for post-indexed indirect.
- R2: A read-class instruction in mode 5 or 7 with `page_cross` set costs one extra cycle. In mode 3 or 6, `page_cross` adds nothing.
- R3: A read-class instruction with `is_write` set in mode 5 or 7 always pays the one extra cycle, whether or not `page_cross` is set.
- R4: Class 1 costs 2 in mode 0, 5 in mode 2, 6 in mode 3, 6 in mode 4 and 7 in mode 5. `page_cross` has no effect on this class.
- R5: In mode 0, classes 2, 3, 4, 5 and 6 cost 2, 3, 4, 6 and 7 cycles.
- R6: Class 7 in mode 9 costs 2 when `br_taken` is clear. It costs 3 when `br_taken` is set, and 4 when `br_taken` and `page_cross` are both set.
- R7: Class 8 costs 3 in mode 4 and 5 in mode 8. Class 9 costs 6 in mode 4.
- R8: Any other pairing of class and mode, including an immediate read with `is_write` set, costs 2 and shows `err` high for that instruction.
- R9: After `start` is accepted, `busy` is high for exactly `cost` consecutive cycles. `done` is high for exactly one cycle, in the cycle that follows the last busy cycle.
- R10: The descriptor inputs are used only in the cycle that `start` is accepted. Changing them while busy alters neither `cost`, `err` nor the busy length.
- R11: A `start` in the final busy cycle is accepted: `busy` stays high, `done` still pulses, and the next instruction runs its full length. A `start` in any earlier busy cycle is ignored.
- R12: A synchronous active-high `rst` clears `busy`, `done`, `cost` and `err`, even in the middle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin timing an instruction |
| tclass | input | 4 | Timing class code |
| amode | input | 4 | Addressing mode code |
| is_write | input | 1 | The access is a store |
| page_cross | input | 1 | Indexing or the branch target crossed a page |
| br_taken | input | 1 | The branch is taken |
| busy | output | 1 | Instruction cycles are being spent |
| done | output | 1 | One-cycle pulse after the last busy cycle |
| cost | output | COST_W | Latched cycle cost of the current instruction |
| err | output | 1 | The latched descriptor was an illegal combination |

## Verification
The hardest case to reach from the ports is a `start` that lands in exactly the final busy cycle. The stimulus uses the reference cost to count down the busy cycles and raise `start` in that one cycle. A second test raises `start` one cycle early, which must be ignored. Every class and mode pairing is swept with all write, page and taken flags. During each busy period the descriptor is scrambled, to show that only the values present at `start` count.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
  localparam int CLS_W  = 4;
  localparam int MODE_W = 4;

  typedef enum logic [CLS_W-1:0] {
    TC_READ    = 4'd0,
    TC_RMW     = 4'd1,
    TC_SIMPLE  = 4'd2,
    TC_PUSH    = 4'd3,
    TC_PULL    = 4'd4,
    TC_RETURN  = 4'd5,
    TC_BREAK   = 4'd6,
    TC_BRANCH  = 4'd7,
    TC_JUMP    = 4'd8,
    TC_CALL    = 4'd9
  } tclass_e;

  typedef enum logic [MODE_W-1:0] {
    AM_NONE    = 4'd0,
    AM_IMM     = 4'd1,
    AM_ZP      = 4'd2,
    AM_ZPX     = 4'd3,
    AM_ABS     = 4'd4,
    AM_ABSX    = 4'd5,
    AM_PREIDX  = 4'd6,
    AM_POSTIDX = 4'd7,
    AM_IND     = 4'd8,
    AM_REL     = 4'd9
  } amode_e;
endpackage

// File: rtl/cyc_cost_calc.sv
module cyc_cost_calc
  import cyc_pkg::*;
#(
  parameter int COST_W = 4
) (
  input  logic [CLS_W-1:0]  cls,
  input  logic [MODE_W-1:0] mode,
  input  logic              wr,
  input  logic              pg,
  input  logic              tk,
  output logic [COST_W-1:0] cost,
  output logic              bad
);
  logic [COST_W-1:0] base;
  logic              illegal;
  logic              idx_pen;
  logic              br_take;
  logic              br_far;

  // base figure per class and mode
  always_comb begin
    base    = COST_W'(2);
    illegal = 1'b0;
    case (cls)
      TC_READ: begin
        case (mode)
          AM_IMM:     begin base = COST_W'(2); illegal = wr; end
          AM_ZP:      base = COST_W'(3);
          AM_ZPX:     base = COST_W'(4);
          AM_ABS:     base = COST_W'(4);
          AM_ABSX:    base = COST_W'(4);
          AM_PREIDX:  base = COST_W'(6);
          AM_POSTIDX: base = COST_W'(5);
          default:    illegal = 1'b1;
        endcase
      end
      TC_RMW: begin
        case (mode)
          AM_NONE: base = COST_W'(2);
          AM_ZP:   base = COST_W'(5);
          AM_ZPX:  base = COST_W'(6);
          AM_ABS:  base = COST_W'(6);
          AM_ABSX: base = COST_W'(7);
          default: illegal = 1'b1;
        endcase
      end
      TC_SIMPLE: illegal = (mode != AM_NONE);
      TC_PUSH:   begin base = COST_W'(3); illegal = (mode != AM_NONE); end
      TC_PULL:   begin base = COST_W'(4); illegal = (mode != AM_NONE); end
      TC_RETURN: begin base = COST_W'(6); illegal = (mode != AM_NONE); end
      TC_BREAK:  begin base = COST_W'(7); illegal = (mode != AM_NONE); end
      TC_BRANCH: illegal = (mode != AM_REL);
      TC_JUMP: begin
        case (mode)
          AM_ABS:  base = COST_W'(3);
          AM_IND:  base = COST_W'(5);
          default: illegal = 1'b1;
        endcase
      end
      TC_CALL: begin base = COST_W'(6); illegal = (mode != AM_ABS); end
      default: illegal = 1'b1;
    endcase
  end

  // additive penalties: only non-wrapping indexed reads see the page flag
  assign idx_pen = (cls == TC_READ) && ((mode == AM_ABSX) || (mode == AM_POSTIDX)) && (wr || pg);
  assign br_take = (cls == TC_BRANCH) && (mode == AM_REL) && tk;
  assign br_far  = br_take && pg;

  assign bad  = illegal;
  assign cost = illegal ? COST_W'(2)
                        : base + COST_W'(idx_pen) + COST_W'(br_take) + COST_W'(br_far);
endmodule

// File: rtl/cyc_stall_ctr.sv
module cyc_stall_ctr #(
  parameter int COST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [COST_W-1:0] load,
  output logic              busy,
  output logic              done,
  output logic              accept
);
  logic [COST_W-1:0] cnt;
  logic              last;

  assign last   = busy && (cnt == COST_W'(1));
  assign accept = start && (!busy || last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        cnt  <= load;
        busy <= 1'b1;
      end else if (busy) begin
        cnt  <= cnt - COST_W'(1);
        busy <= !last;
      end
    end
  end
endmodule

// File: rtl/cyc_timer.sv
module cyc_timer
  import cyc_pkg::*;
#(
  parameter int COST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CLS_W-1:0]  tclass,
  input  logic [MODE_W-1:0] amode,
  input  logic              is_write,
  input  logic              page_cross,
  input  logic              br_taken,
  output logic              busy,
  output logic              done,
  output logic [COST_W-1:0] cost,
  output logic              err
);
  logic [COST_W-1:0] calc_cost;
  logic              calc_bad;
  logic              accept;

  cyc_cost_calc #(.COST_W(COST_W)) u_calc (
    .cls  (tclass),
    .mode (amode),
    .wr   (is_write),
    .pg   (page_cross),
    .tk   (br_taken),
    .cost (calc_cost),
    .bad  (calc_bad)
  );

  cyc_stall_ctr #(.COST_W(COST_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .load   (calc_cost),
    .busy   (busy),
    .done   (done),
    .accept (accept)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cost <= '0;
      err  <= 1'b0;
    end else if (accept) begin
      cost <= calc_cost;
      err  <= calc_bad;
    end
  end
endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk #(
  parameter int COST_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [COST_W-1:0] cost,
  input logic              err
);
  assert_err_cost_R8: assert property (@(posedge clk) disable iff (rst)
    err |-> (cost == COST_W'(2)));

  assert_cost_min_R1: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cost >= COST_W'(2)));

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idle_start_R9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_busy_fall_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(busy)) |-> done);

  assert_cost_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !done) |-> $stable(cost));
endmodule

bind cyc_timer cyc_timer_chk #(.COST_W(COST_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .cost  (cost),
  .err   (err)
);

// File: tb/cyc_timer_test.sv
module cyc_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int COST_W     = 4;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [3:0]        tclass = '0;
  logic [3:0]        amode = '0;
  logic              is_write = 1'b0;
  logic              page_cross = 1'b0;
  logic              br_taken = 1'b0;
  logic              busy, done, err;
  logic [COST_W-1:0] cost;

  cyc_timer #(.COST_W(COST_W)) uut (
    .clk(clk), .rst(rst), .start(start), .tclass(tclass), .amode(amode),
    .is_write(is_write), .page_cross(page_cross), .br_taken(br_taken),
    .busy(busy), .done(done), .cost(cost), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    n;
    bit    e;
    string tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  int   run_len = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic exp_t ref_cost(input int c, input int m, input bit w, input bit p, input bit t);
    exp_t r;
    r.n = -1; r.e = 1'b0; r.tag = "R8";
    case (c)
      0: begin
        case (m)
          1: r.n = w ? -1 : 2;
          2: r.n = 3;
          3, 4: r.n = 4;
          5: r.n = (w || p) ? 5 : 4;
          6: r.n = 6;
          7: r.n = (w || p) ? 6 : 5;
          default: r.n = -1;
        endcase
        if ((m == 5 || m == 7) && w) r.tag = "R3";
        else if ((m == 3 || m == 5 || m == 6 || m == 7) && p) r.tag = "R2";
        else r.tag = "R1";
      end
      1: begin
        r.tag = "R4";
        if (m == 0) r.n = 2;
        else if (m == 2) r.n = 5;
        else if (m == 3 || m == 4) r.n = 6;
        else if (m == 5) r.n = 7;
      end
      2: begin r.tag = "R5"; if (m == 0) r.n = 2; end
      3: begin r.tag = "R5"; if (m == 0) r.n = 3; end
      4: begin r.tag = "R5"; if (m == 0) r.n = 4; end
      5: begin r.tag = "R5"; if (m == 0) r.n = 6; end
      6: begin r.tag = "R5"; if (m == 0) r.n = 7; end
      7: begin r.tag = "R6"; if (m == 9) r.n = 2 + (t ? 1 : 0) + ((t && p) ? 1 : 0); end
      8: begin r.tag = "R7"; if (m == 4) r.n = 3; else if (m == 8) r.n = 5; end
      9: begin r.tag = "R7"; if (m == 4) r.n = 6; end
      default: r.n = -1;
    endcase
    if (r.n < 0) begin
      r.n = 2; r.e = 1'b1; r.tag = "R8";
    end
    return r;
  endfunction

  // driver: waits for idle, pushes expectation, pulses start, scrambles inputs (R10)
  task automatic issue(input int c, input int m, input bit w, input bit p, input bit t);
    while (busy) @(negedge clk);
    q.push_back(ref_cost(c, m, w, p, t));
    tclass = 4'(c); amode = 4'(m); is_write = w; page_cross = p; br_taken = t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tclass = ~tclass; amode = amode + 4'd3;
    is_write = ~w; page_cross = ~p; br_taken = ~t;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst) begin
      run_len = 0;
    end else begin
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9", 1, 0, "unexpected done");
        end else begin
          exp_t it;
          it = q.pop_front();
          chk(run_len == it.n, "R9", run_len, it.n, "busy length");
        end
        run_len = 0;
      end
      if (busy) begin
        if (run_len == 0 && q.size() > 0) begin
          chk(int'(cost) == q[0].n, q[0].tag, int'(cost), q[0].n, "cost");
          chk(err == q[0].e, q[0].tag, int'(err), int'(q[0].e), "err");
        end
        run_len++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic drain();
    while (busy || q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(busy == 1'b0, "R12", int'(busy), 0, "busy after reset");
    chk(done == 1'b0, "R12", int'(done), 0, "done after reset");
    chk(cost == '0,   "R12", int'(cost), 0, "cost after reset");
    chk(err == 1'b0,  "R12", int'(err), 0, "err after reset");

    // full sweep of class/mode/flags (R1..R8, R9, R10)
    for (int c = 0; c < 16; c++)
      for (int m = 0; m < 16; m++)
        for (int f = 0; f < 8; f++)
          issue(c, m, f[0], f[1], f[2]);
    drain();

    // R11 back-to-back: start in the final busy cycle of a break (7)
    issue(6, 0, 1'b0, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    chk(busy == 1'b1, "R11", int'(busy), 1, "busy in last cycle");
    q.push_back(ref_cost(0, 5, 1'b0, 1'b1, 1'b0));
    tclass = 4'd0; amode = 4'd5; is_write = 1'b0; page_cross = 1'b1; br_taken = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R11", int'(done), 1, "done on handover");
    chk(busy == 1'b1, "R11", int'(busy), 1, "busy kept on handover");
    drain();

    // R11 early start ignored
    issue(6, 0, 1'b0, 1'b0, 1'b0);
    tclass = 4'd2; amode = 4'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    chk(busy == 1'b0, "R11", int'(busy), 0, "early start ignored");
    chk(q.size() == 0, "R11", q.size(), 0, "queue empty");

    // R12 reset mid-instruction
    issue(6, 0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    q.delete();
    chk(busy == 1'b0, "R12", int'(busy), 0, "busy after mid reset");
    chk(done == 1'b0, "R12", int'(done), 0, "done after mid reset");
    chk(cost == '0,   "R12", int'(cost), 0, "cost after mid reset");
    repeat (9) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R12", int'(busy) + int'(done), 0, "stays idle");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule